// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Claim/Complete

This block collects level-sensitive interrupt requests from a parameterized set of numbered global sources. It forwards them to several target contexts, each standing for one privilege mode of one hardware thread. Every source carries a programmable priority. Every context holds its own enable bit per source and its own priority threshold. A context's interrupt line is raised when at least one pending source is enabled for it and has a priority above its threshold.

Software handles an interrupt in three steps. It reads the context's claim word, which returns the best qualifying source number and takes that source out of circulation. It services the device. It then writes the same number back to the claim word to complete it. The handler repeats claim reads until it reads 0. All state is reached through a 32-bit register port. Each access is presented for one cycle and is answered one cycle later.

Top module: `intr_hub`

## Requirements
- R1: After reset, every context interrupt output is low and every priority, enable, threshold and claim word reads 0.
- R2: The priority of source n (1 <= n <= NSRC) is held at byte offset 4*n and keeps its low PRIO_W bits; upper bits read 0. The word at offset 0 stands for the reserved number 0, which is never a source: it reads 0 and ignores writes.
- R3: The enable word w of context c is at offset 0x2000 + 0x80*c + 4*w. Bit (n mod 32) of word (n / 32) enables source n. Bit 0 of word 0 (number 0) always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and keeps its low PRIO_W bits. The claim/complete word of context c is at the next word, +4.
- R5: A source can drive a context's output only when it is pending, enabled for that context and its priority is strictly greater than the context's threshold. A priority of 0 therefore never interrupts. The output is registered and follows a change of priority, enable, threshold or pending state one cycle later.
- R6: A claim read returns the number of the qualifying source with the highest priority, the lowest number winning among equals, or 0 when none qualifies.
- R7: A claim read that returns n clears the pending state of source n in the same access. Source n then stays out of circulation even while its input stays high, so a second claim does not return it.
- R8: Writing n to a claim/complete word returns source n to circulation, provided n is in flight and enabled for that context. A source whose input is still high becomes pending again afterwards.
- R9: A completion write whose number is not in flight, or is not enabled for the writing context, has no effect.
- R10: Contexts are independent: enables and thresholds of one context do not change the output or the claim result of another.
- R11: Every access raises regAck in the following cycle, and read data is valid on regRdata in that cycle.
- R12: Reads of unimplemented offsets (gaps, absent contexts, absent sources) return 0, and writes to them change nothing.
- R13: Source input bit k (srcLevel[k]) is the request of source number k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NSRC | Level requests; bit k belongs to source k+1 |
| regReq | input | 1 | Register access strobe, one cycle per access |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while regAck is high |
| regAck | output | 1 | Access answered, one cycle after regReq |
| irqOut | output | NCTX | Interrupt request per context |

## Verification
The routing is tried with one source whose priority moves from 0 upward against a threshold that is raised and lowered. This separates the strict-greater rule from a greater-or-equal rule and shows the one-cycle output latency. Three sources with two equal top priorities and one lower priority are then claimed in turn. This tells ordering by priority apart from ordering by number, and shows the tie going to the lower number. A source enabled for only one context shows that the contexts do not leak into each other. Claims with the input held high, and completions with wrong numbers or from a context without the enable, separate genuine re-arming from spurious re-pending.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } accKind_e;

  typedef struct packed {
    accKind_e    kind;
    logic        wr;
    logic [13:0] ctx;
    logic [9:0]  idx;
  } accStrobe_t;
endpackage

// File: rtl/intr_hub_ctrl.sv
module intr_hub_ctrl
  import intr_hub_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output accStrobe_t        strobe,
  output logic              regAck
);
  localparam int NWORD = NSRC / 32 + 1;

  logic [31:0] byteAddr;
  logic [31:0] slotIdx;
  logic [31:0] ctxOff;

  always_comb begin
    byteAddr    = 32'(regAddr);
    strobe      = '0;
    strobe.kind = ACC_NONE;
    strobe.wr   = regWe;
    slotIdx     = '0;
    ctxOff      = '0;
    if (regReq && byteAddr[1:0] == 2'b00) begin
      if (byteAddr < 32'h1000) begin
        slotIdx = {22'b0, byteAddr[11:2]};
        if (slotIdx >= 32'd1 && slotIdx <= 32'(NSRC)) begin
          strobe.kind = ACC_PRIO;
          strobe.idx  = slotIdx[9:0];
        end
      end else if (byteAddr >= 32'h2000 && byteAddr < 32'h20_0000) begin
        ctxOff  = (byteAddr - 32'h2000) >> 7;
        slotIdx = {27'b0, byteAddr[6:2]};
        if (ctxOff < 32'(NCTX) && slotIdx < 32'(NWORD)) begin
          strobe.kind = ACC_EN;
          strobe.ctx  = ctxOff[13:0];
          strobe.idx  = slotIdx[9:0];
        end
      end else if (byteAddr >= 32'h20_0000) begin
        ctxOff = (byteAddr - 32'h20_0000) >> 12;
        if (ctxOff < 32'(NCTX)) begin
          strobe.ctx = ctxOff[13:0];
          if (byteAddr[11:0] == 12'h000) strobe.kind = ACC_THR;
          else if (byteAddr[11:0] == 12'h004) strobe.kind = ACC_CLAIM;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regAck <= 1'b0;
    else       regAck <= regReq;
  end
endmodule

// File: rtl/intr_hub_arb.sv
module intr_hub_arb #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC:1]          cand,
  input  logic [NSRC*PRIO_W-1:0] prioFlat,
  input  logic [PRIO_W-1:0]      thr,
  output logic [ID_W-1:0]        bestId
);
  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] curPrio;

  // Ascending scan with strict compare keeps the lowest number on ties.
  always_comb begin
    bestPrio = '0;
    bestId   = '0;
    curPrio  = '0;
    for (int s = 1; s <= NSRC; s++) begin
      curPrio = prioFlat[(s-1)*PRIO_W +: PRIO_W];
      if (cand[s] && curPrio > thr && curPrio > bestPrio) begin
        bestPrio = curPrio;
        bestId   = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/intr_hub_dp.sv
module intr_hub_dp
  import intr_hub_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcLevel,
  input  accStrobe_t      strobe,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output logic [NCTX-1:0] irqOut,
  output logic [NSRC:1]   pendQ,
  output logic [NSRC:1]   flightQ
);
  localparam int ID_W = $clog2(NSRC + 1);

  logic [NSRC*PRIO_W-1:0] prioQ;
  logic [NSRC:1]          enQ    [NCTX];
  logic [PRIO_W-1:0]      thrQ   [NCTX];
  logic [ID_W-1:0]        bestId [NCTX];
  logic [NSRC:1]          levelVec;
  logic [NSRC:1]          claimMask;
  logic [NSRC:1]          complMask;
  logic [NSRC:1]          selEn;
  logic [PRIO_W-1:0]      selThr;
  logic [ID_W-1:0]        selBest;
  logic [31:0]            readMux;

  assign levelVec = srcLevel;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    intr_hub_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand    (pendQ & enQ[c]),
      .prioFlat(prioQ),
      .thr     (thrQ[c]),
      .bestId  (bestId[c])
    );
  end

  always_comb begin
    selEn   = '0;
    selThr  = '0;
    selBest = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (32'(strobe.ctx) == 32'(c)) begin
        selEn   = enQ[c];
        selThr  = thrQ[c];
        selBest = bestId[c];
      end
    end
  end

  always_comb begin
    claimMask = '0;
    complMask = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (strobe.kind == ACC_CLAIM && !strobe.wr && 32'(selBest) == 32'(s))
        claimMask[s] = 1'b1;
      if (strobe.kind == ACC_CLAIM && strobe.wr && regWdata == 32'(s) &&
          flightQ[s] && selEn[s])
        complMask[s] = 1'b1;
    end
  end

  always_comb begin
    readMux = '0;
    case (strobe.kind)
      ACC_PRIO: begin
        for (int s = 1; s <= NSRC; s++)
          if (32'(strobe.idx) == 32'(s))
            readMux[PRIO_W-1:0] = prioQ[(s-1)*PRIO_W +: PRIO_W];
      end
      ACC_EN: begin
        for (int s = 1; s <= NSRC; s++)
          if (32'(strobe.idx) == 32'(s / 32))
            readMux[s % 32] = selEn[s];
      end
      ACC_THR:   readMux[PRIO_W-1:0] = selThr;
      ACC_CLAIM: readMux[ID_W-1:0]   = selBest;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioQ    <= '0;
      pendQ    <= '0;
      flightQ  <= '0;
      irqOut   <= '0;
      regRdata <= '0;
      for (int c = 0; c < NCTX; c++) begin
        enQ[c]  <= '0;
        thrQ[c] <= '0;
      end
    end else begin
      pendQ    <= (pendQ | (levelVec & ~flightQ)) & ~claimMask;
      flightQ  <= (flightQ | claimMask) & ~complMask;
      regRdata <= strobe.wr ? 32'd0 : readMux;
      for (int c = 0; c < NCTX; c++)
        irqOut[c] <= (bestId[c] != '0);
      if (strobe.wr) begin
        if (strobe.kind == ACC_PRIO) begin
          for (int s = 1; s <= NSRC; s++)
            if (32'(strobe.idx) == 32'(s))
              prioQ[(s-1)*PRIO_W +: PRIO_W] <= regWdata[PRIO_W-1:0];
        end
        for (int c = 0; c < NCTX; c++) begin
          if (32'(strobe.ctx) == 32'(c)) begin
            if (strobe.kind == ACC_THR) thrQ[c] <= regWdata[PRIO_W-1:0];
            if (strobe.kind == ACC_EN) begin
              for (int s = 1; s <= NSRC; s++)
                if (32'(strobe.idx) == 32'(s / 32))
                  enQ[c][s] <= regWdata[s % 32];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcLevel,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regAck,
  output logic [NCTX-1:0]   irqOut
);
  accStrobe_t    strobe;
  logic [NSRC:1] pendQ;
  logic [NSRC:1] flightQ;

  intr_hub_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regReq (regReq),
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobe (strobe),
    .regAck (regAck)
  );

  intr_hub_dp #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcLevel(srcLevel),
    .strobe  (strobe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut),
    .pendQ   (pendQ),
    .flightQ (flightQ)
  );
endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              regReq,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic              regAck,
  input logic [NCTX-1:0]   irqOut,
  input logic [NSRC:1]     pendQ,
  input logic [NSRC:1]     flightQ
);
  localparam logic [ADDR_W-1:0] CLAIM0 = ADDR_W'(32'h20_0004);

  logic [NSRC:0] flightShift;
  assign flightShift = {flightQ, 1'b0} >> regRdata;

  // R11: every access is answered in the next cycle
  a_r11_ack_follows: assert property (@(posedge clk) disable iff (!rstN)
    regReq |=> regAck);

  // R7: a source is never pending and in flight at once
  a_r7_pend_or_flight: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & flightQ) == '0);

  // R7: a nonzero claim on context 0 leaves that source in flight
  a_r7_claim_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWe && regAddr == CLAIM0) |=> (regRdata == 32'd0 || flightShift[0]));

  // R9: a source leaves flight only through a register write
  a_r9_release_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flightQ) & ~flightQ)) |-> $past(regReq && regWe));

  // R5: nothing pending means every output is low one cycle later
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |=> (irqOut == '0));
endmodule

bind intr_hub intr_hub_chk #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regReq  (regReq),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regRdata(regRdata),
  .regAck  (regAck),
  .irqOut  (irqOut),
  .pendQ   (pendQ),
  .flightQ (flightQ)
);

// File: tb/sim_intr_hub.sv
module sim_intr_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC   = 31;
  localparam int NCTX   = 2;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 26;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NSRC-1:0]   srcLevel = '0;
  logic              regReq = 1'b0;
  logic              regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              regAck;
  logic [NCTX-1:0]   irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .regReq(regReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] prioAddr(int id);  return 32'(id * 4); endfunction
  function automatic logic [31:0] enAddr(int c, int w); return 32'(32'h2000 + 32'h80 * c + 4 * w); endfunction
  function automatic logic [31:0] thrAddr(int c);    return 32'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [31:0] claimAddr(int c);  return thrAddr(c) + 32'd4; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [31:0] addr, logic [31:0] data);
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b1; regAddr = ADDR_W'(addr); regWdata = data;
    @(negedge clk);
    regReq = 1'b0; regWe = 1'b0;
  endtask

  task automatic regRead(logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b0; regAddr = ADDR_W'(addr);
    @(negedge clk);
    regReq = 1'b0;
    check("R11 ack", 32'(regAck), 32'd1);
    data = regRdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLevel(int id, logic v);
    @(negedge clk);
    srcLevel[id-1] = v;  // R13: bit k is source k+1
  endtask

  task automatic tReset();
    logic [31:0] d;
    check("R1 irq", 32'(irqOut), 32'd0);
    regRead(prioAddr(1), d);  check("R1 prio", d, 0);
    regRead(enAddr(0, 0), d); check("R1 enable", d, 0);
    regRead(thrAddr(1), d);   check("R1 threshold", d, 0);
    regRead(claimAddr(0), d); check("R1 claim", d, 0);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    regWrite(prioAddr(5), 32'hFFFF_FFFF);
    regRead(prioAddr(5), d); check("R2 prio width", d, 32'h7);
    regWrite(prioAddr(0), 32'h5);
    regRead(prioAddr(0), d); check("R2 reserved id0", d, 0);
    regWrite(enAddr(1, 0), 32'hFFFF_FFFF);
    regRead(enAddr(1, 0), d); check("R3 enable bits", d, 32'hFFFF_FFFE);
    regRead(enAddr(0, 0), d); check("R10 enable other ctx", d, 0);
    regWrite(enAddr(1, 0), 32'h0);
    regWrite(thrAddr(1), 32'hFF);
    regRead(thrAddr(1), d); check("R4 threshold width", d, 32'h7);
    regWrite(thrAddr(1), 32'h0);
  endtask

  task automatic tRouting();
    logic [31:0] d;
    regWrite(enAddr(0, 0), 32'h1 << 3);
    setLevel(3, 1'b1);
    settle(3);
    check("R5 prio0 silent", 32'(irqOut[0]), 0);
    regWrite(prioAddr(3), 32'd2);
    check("R5 latency low", 32'(irqOut[0]), 0);
    settle(1);
    check("R5 latency high", 32'(irqOut[0]), 1);
    check("R10 ctx1 quiet", 32'(irqOut[1]), 0);
    regWrite(thrAddr(0), 32'd2);
    settle(2);
    check("R5 strict greater", 32'(irqOut[0]), 0);
    regRead(claimAddr(0), d); check("R6 none over threshold", d, 0);
    regWrite(thrAddr(0), 32'd1);
    settle(2);
    check("R5 above threshold", 32'(irqOut[0]), 1);
  endtask

  task automatic tClaim();
    logic [31:0] d;
    regRead(claimAddr(0), d); check("R6 claim id", d, 3);
    settle(2);
    check("R7 irq drops", 32'(irqOut[0]), 0);
    regRead(claimAddr(0), d); check("R7 held off", d, 0);
    regWrite(claimAddr(0), 32'd5);
    regWrite(claimAddr(1), 32'd3);
    settle(3);
    check("R9 bad completion irq", 32'(irqOut[0]), 0);
    regRead(claimAddr(0), d); check("R9 bad completion", d, 0);
    regWrite(claimAddr(0), 32'd3);
    settle(3);
    check("R8 re-pend irq", 32'(irqOut[0]), 1);
    regRead(claimAddr(0), d); check("R8 reclaim", d, 3);
    setLevel(3, 1'b0);
    regWrite(claimAddr(0), 32'd3);
    settle(3);
    check("R8 level low stays idle", 32'(irqOut[0]), 0);
    regRead(claimAddr(0), d); check("R8 nothing left", d, 0);
  endtask

  task automatic tArbitration();
    logic [31:0] d;
    regWrite(prioAddr(4), 32'd5);
    regWrite(prioAddr(6), 32'd5);
    regWrite(prioAddr(2), 32'd3);
    regWrite(enAddr(0, 0), (32'h1 << 2) | (32'h1 << 4) | (32'h1 << 6));
    setLevel(2, 1'b1); setLevel(4, 1'b1); setLevel(6, 1'b1);
    settle(3);
    regRead(claimAddr(0), d); check("R6 tie lowest id", d, 4);
    regRead(claimAddr(0), d); check("R6 next equal prio", d, 6);
    regRead(claimAddr(0), d); check("R6 lower prio last", d, 2);
    regRead(claimAddr(0), d); check("R6 drained", d, 0);
    setLevel(2, 1'b0); setLevel(4, 1'b0); setLevel(6, 1'b0);
    regWrite(claimAddr(0), 32'd4);
    regWrite(claimAddr(0), 32'd6);
    regWrite(claimAddr(0), 32'd2);
    settle(3);
    check("R8 all completed", 32'(irqOut), 0);
  endtask

  task automatic tContexts();
    logic [31:0] d;
    regWrite(prioAddr(7), 32'd1);
    regWrite(enAddr(1, 0), 32'h1 << 7);
    setLevel(7, 1'b1);
    settle(3);
    check("R10 ctx1 raised", 32'(irqOut[1]), 1);
    check("R10 ctx0 unaffected", 32'(irqOut[0]), 0);
    regRead(claimAddr(0), d); check("R10 ctx0 claim", d, 0);
    regRead(claimAddr(1), d); check("R10 ctx1 claim", d, 7);
    setLevel(7, 1'b0);
    regWrite(claimAddr(1), 32'd7);
    settle(3);
    check("R8 ctx1 idle", 32'(irqOut[1]), 0);
  endtask

  task automatic tUnimplemented();
    logic [31:0] d;
    regWrite(32'h1000, 32'hFFFF_FFFF);
    regRead(32'h1000, d);  check("R12 gap", d, 0);
    regWrite(prioAddr(32), 32'h7);
    regRead(prioAddr(32), d); check("R12 absent source", d, 0);
    regWrite(thrAddr(0) + 32'd8, 32'h7);
    regRead(thrAddr(0) + 32'd8, d); check("R12 context hole", d, 0);
    regWrite(thrAddr(2), 32'h7);
    regRead(thrAddr(2), d); check("R12 absent context", d, 0);
    regRead(thrAddr(0), d); check("R12 threshold untouched", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tRouting();
    tClaim();
    tArbitration();
    tContexts();
    tUnimplemented();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule